// File: doc/BRIEF.md
# Serial Control-Byte Register Access Unit

This unit sits behind a frame sequencer on a serial codec port. For each received 8-bit control byte it decides whether a register access takes place, then carries it out against a 16-entry, 8-bit register file. A write takes its value from the next register-data slot of the same repetition cycle. A read captures the addressed register when the control byte arrives.

On the transmit side it rebuilds the control field. The low six bits repeat the byte received one repetition cycle earlier. The top two bits carry sample-validity flags or the sync marker, depending on the port mode. The register-data field returns read results one frame after the echo. In dual-port mode it checks the sync marker, enforces which port may reach which codec's registers, and keeps a sticky flag for misrouted accesses.

The sequencer pulses `frame_strb` once at the start of every frame. It pulses `ctl_vld` when the control slot is present and `reg_vld` when the register-data slot is present. The mode, the port index, the power-down flags and the new-sample flags are held steady by the surrounding logic.

Top module: `ctl_reg_access`

## Requirements
- R1: A control byte with bit 5 = 1 and bit 4 = 0 arms a write to the register addressed by bits 3:0. The next `reg_vld` writes `reg_wdata` there, so that `regs_flat[8*a +: 8]` holds it from the following cycle. No other register changes, and a later control byte replaces an armed write that has not yet been performed.
- R2: A control byte with bit 5 = 0 accesses nothing. The following register-data slot changes no register, and no read data is returned for it.
- R3: A control byte with bits 5:4 = 11 reads the addressed register as it stands when the byte arrives. The value appears on `tx_reg` during the frame that comes L+1 frames after the byte's frame. `tx_reg` is 0 in frames with no accepted read to return.
- R4: In dual mode (`mode[1]` = 0), a control byte whose bit 6 is 0 is ignored entirely. It arms no write, returns no read and sets no error.
- R5: During frame k, `tx_ctl[5:0]` equals bits 5:0 of the control byte received in frame k−L, or 0 if that frame carried none or lies before reset. L is 3 in 16-bit single mode (`mode` = 2'b10) and 2 in the other modes (`mode[0]` = 1 marks 24-bit).
- R6: `tx_ctl[7]` is 0 whenever `cdc_pd[0]` is 1.
- R7: In single mode, `tx_ctl[7]` = `smp_new[0]` & ~`cdc_pd[0]` and `tx_ctl[6]` = `smp_new[1]` & ~`cdc_pd[1]`.
- R8: In dual mode, `tx_ctl[6]` is 1 and `tx_ctl[7]` is ~`cdc_pd[0]`.
- R9: In dual mode, an access to addresses 0x0–0x7 whose bit 0 differs from `port_idx` is dropped and sets `err_sticky` until reset. Addresses 0x8–0xF are reachable from either port. Single mode accepts every address.
- R10: Reset clears all registers, `err_sticky`, `tx_reg` and the echoed control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | bit1: 1 = single, 0 = dual; bit0: 1 = 24-bit, 0 = 16-bit |
| port_idx | input | 1 | Serial port this unit serves (dual mode) |
| frame_strb | input | 1 | Start-of-frame pulse |
| ctl_vld | input | 1 | Control byte present |
| ctl_byte | input | 8 | Received control byte |
| reg_vld | input | 1 | Register-data slot present |
| reg_wdata | input | 8 | Received register data |
| cdc_pd | input | 2 | Codec power-down flags |
| smp_new | input | 2 | Codec has a fresh sample this repetition (single mode) |
| tx_ctl | output | 8 | Transmit control field |
| tx_reg | output | 8 | Transmit register-data field (read result) |
| regs_flat | output | 128 | Register contents, register a at bits 8a+7:8a |
| err_sticky | output | 1 | Misrouted dual-mode access seen |

## Verification
Every address is written and then read back from both port indices in all four modes. This separates correct port-routing decisions from wrongly dropped or wrongly accepted codec-specific accesses, and it shows the echo and read latencies moving between two and three frames. In 24-bit dual mode the register data arrives a frame after its control byte, which tests that an armed write is held across frame boundaries. Control bytes with the enable bit low, and dual-mode bytes with the marker bit low, are followed by data slots with a distinct value, so any leak shows up in the register contents. A sweep over all power-down and new-sample combinations in each mode separates the validity rules from the dual-mode marker rule.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  // port mode: bit1 selects single (1) / dual (0), bit0 selects 24-bit (1) / 16-bit (0)
  typedef enum logic [1:0] {
    MD_DUAL16 = 2'b00,
    MD_DUAL24 = 2'b01,
    MD_SNG16  = 2'b10,
    MD_SNG24  = 2'b11
  } port_mode_e;

  // stage of the echo pipe that holds the byte from L frames ago (stage 0 = one frame ago)
  function automatic logic [1:0] echo_tap(input logic [1:0] m);
    return (m == MD_SNG16) ? 2'd2 : 2'd1;
  endfunction

  // read data trails the echo by one frame
  function automatic logic [1:0] read_tap(input logic [1:0] m);
    return echo_tap(m) + 2'd1;
  endfunction

  function automatic logic is_dual(input logic [1:0] m);
    return !m[1];
  endfunction

  // lower half of the address space is codec specific
  function automatic logic codec_addr(input logic [3:0] a);
    return !a[3];
  endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_reg_pkg::*;
#(
  parameter int AW = 4,
  localparam int CW = AW + 4
) (
  input  logic [CW-1:0] byte_i,
  input  logic [1:0]    mode,
  input  logic          port_idx,
  output logic          acc_wr,
  output logic          acc_rd,
  output logic          desync,
  output logic          misroute
);
  logic          aen;
  logic          rwb;
  logic          marker;
  logic [AW-1:0] addr;

  assign aen    = byte_i[AW+1];
  assign rwb    = byte_i[AW];
  assign marker = byte_i[AW+2];
  assign addr   = byte_i[AW-1:0];

  always_comb begin
    desync   = is_dual(mode) && !marker;
    misroute = aen && !desync && is_dual(mode) && !addr[AW-1] && (addr[0] != port_idx);
    acc_wr   = aen && !desync && !misroute && !rwb;
    acc_rd   = aen && !desync && !misroute && rwb;
  end
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int NREG = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DW-1:0]     rdata,
  output logic [NREG*DW-1:0] flat
);
  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                    mem[g] <= '0;
      else if (we && (waddr == AW'(g)))              mem[g] <= wdata;
    end
    assign flat[g*DW +: DW] = mem[g];
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ctl_echo_pipe.sv
module ctl_echo_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shift,
  input  logic [W-1:0]             din,
  output logic [DEPTH-1:0][W-1:0]  taps
);
  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     stg[g] <= '0;
        else if (shift) stg[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)     stg[g] <= '0;
        else if (shift) stg[g] <= stg[g-1];
      end
    end
    assign taps[g] = stg[g];
  end
endmodule

// File: rtl/ctl_reg_access.sv
module ctl_reg_access
  import ctl_reg_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int CW   = AW + 4,
  localparam int NREG = 1 << AW,
  localparam int ECHO_D = 3,
  localparam int RD_D   = ECHO_D + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               port_idx,
  input  logic               frame_strb,
  input  logic               ctl_vld,
  input  logic [CW-1:0]      ctl_byte,
  input  logic               reg_vld,
  input  logic [DW-1:0]      reg_wdata,
  input  logic [1:0]         cdc_pd,
  input  logic [1:0]         smp_new,
  output logic [CW-1:0]      tx_ctl,
  output logic [DW-1:0]      tx_reg,
  output logic [NREG*DW-1:0] regs_flat,
  output logic               err_sticky
);
  // decode results and named events
  logic          dec_wr, dec_rd, dec_desync, dec_mis;
  logic          wr_arm, rd_arm, mis_ev, wr_fire;
  logic          wr_pend;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] rd_val;
  logic [CW-1:0] cur_ctl, ctl_next;
  logic [DW:0]   cur_rd, rd_next;
  logic [ECHO_D-1:0][CW-1:0] ctl_taps;
  logic [RD_D-1:0][DW:0]     rd_taps;
  logic [DW:0]   rd_sel;
  logic          v0_bit, v1_bit;

  ctl_decode #(.AW(AW)) u_dec (
    .byte_i   (ctl_byte),
    .mode     (mode),
    .port_idx (port_idx),
    .acc_wr   (dec_wr),
    .acc_rd   (dec_rd),
    .desync   (dec_desync),
    .misroute (dec_mis)
  );

  assign wr_arm  = ctl_vld && dec_wr;
  assign rd_arm  = ctl_vld && dec_rd;
  assign mis_ev  = ctl_vld && dec_mis;
  assign wr_fire = reg_vld && wr_pend;

  ctl_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (reg_wdata),
    .raddr (ctl_byte[AW-1:0]),
    .rdata (rd_val),
    .flat  (regs_flat)
  );

  // armed write: set by an accepted write byte, consumed by the data slot,
  // replaced by any newer control byte
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_pend <= 1'b0;
      wr_addr <= '0;
    end else if (ctl_vld) begin
      wr_pend <= dec_wr;
      wr_addr <= ctl_byte[AW-1:0];
    end else if (reg_vld) begin
      wr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      err_sticky <= 1'b0;
    else if (mis_ev) err_sticky <= 1'b1;
  end

  // per-frame collectors: what arrived in the frame now running
  always_comb begin
    ctl_next = frame_strb ? '0 : cur_ctl;
    rd_next  = frame_strb ? '0 : cur_rd;
    if (ctl_vld) ctl_next = ctl_byte;
    if (rd_arm)  rd_next  = {1'b1, rd_val};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_ctl <= '0;
      cur_rd  <= '0;
    end else begin
      cur_ctl <= ctl_next;
      cur_rd  <= rd_next;
    end
  end

  ctl_echo_pipe #(.W(CW), .DEPTH(ECHO_D)) u_echo (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (frame_strb),
    .din   (cur_ctl),
    .taps  (ctl_taps)
  );

  ctl_echo_pipe #(.W(DW + 1), .DEPTH(RD_D)) u_rdq (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (frame_strb),
    .din   (cur_rd),
    .taps  (rd_taps)
  );

  // validity / marker bits
  always_comb begin
    if (is_dual(mode)) begin
      v0_bit = !cdc_pd[0];
      v1_bit = 1'b1;
    end else begin
      v0_bit = smp_new[0] && !cdc_pd[0];
      v1_bit = smp_new[1] && !cdc_pd[1];
    end
  end

  assign rd_sel = rd_taps[read_tap(mode)];
  assign tx_ctl = {v0_bit, v1_bit, ctl_taps[echo_tap(mode)][CW-3:0]};
  assign tx_reg = rd_sel[DW] ? rd_sel[DW-1:0] : '0;
endmodule

// File: rtl/ctl_reg_access_chk.sv
module ctl_reg_access_chk #(
  parameter int DW = 8,
  parameter int AW = 4,
  localparam int CW   = AW + 4,
  localparam int NREG = 1 << AW
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         mode,
  input logic               ctl_vld,
  input logic [CW-1:0]      ctl_byte,
  input logic [1:0]         cdc_pd,
  input logic [CW-1:0]      tx_ctl,
  input logic [NREG*DW-1:0] regs_flat,
  input logic               err_sticky,
  input logic               wr_fire,
  input logic               wr_pend,
  input logic               mis_ev
);
  p_regs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(regs_flat));

  p_off_arms_nothing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_vld && !ctl_byte[AW+1]) |=> !wr_pend);

  p_desync_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_vld && !mode[1] && !ctl_byte[AW+2]) |=> (!wr_pend && $stable(err_sticky)));

  p_v0_powered_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cdc_pd[0] |-> !tx_ctl[CW-1]);

  p_dual_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> tx_ctl[CW-2]);

  p_mis_sets_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mis_ev |=> err_sticky);

  p_err_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

bind ctl_reg_access ctl_reg_access_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .ctl_vld    (ctl_vld),
  .ctl_byte   (ctl_byte),
  .cdc_pd     (cdc_pd),
  .tx_ctl     (tx_ctl),
  .regs_flat  (regs_flat),
  .err_sticky (err_sticky),
  .wr_fire    (wr_fire),
  .wr_pend    (wr_pend),
  .mis_ev     (mis_ev)
);

// File: tb/ctl_reg_access_test.sv
module ctl_reg_access_test;
  localparam int CLK_P = 10;
  localparam int HN    = 4096;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         port_idx = 1'b0;
  logic         frame_strb = 1'b0;
  logic         ctl_vld = 1'b0;
  logic [7:0]   ctl_byte = '0;
  logic         reg_vld = 1'b0;
  logic [7:0]   reg_wdata = '0;
  logic [1:0]   cdc_pd = '0;
  logic [1:0]   smp_new = '0;
  logic [7:0]   tx_ctl;
  logic [7:0]   tx_reg;
  logic [127:0] regs_flat;
  logic         err_sticky;

  int nvec = 0;
  int nbad = 0;
  int k = 0;

  logic [7:0] mregs [16];
  logic [7:0] ctl_hist [HN];
  logic [8:0] rd_hist [HN];
  logic       m_err = 1'b0;
  logic       m_pend = 1'b0;
  logic [3:0] m_waddr = '0;

  ctl_reg_access uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .port_idx(port_idx),
    .frame_strb(frame_strb), .ctl_vld(ctl_vld), .ctl_byte(ctl_byte),
    .reg_vld(reg_vld), .reg_wdata(reg_wdata), .cdc_pd(cdc_pd), .smp_new(smp_new),
    .tx_ctl(tx_ctl), .tx_reg(tx_reg), .regs_flat(regs_flat), .err_sticky(err_sticky)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    nbad++;
    $display("FAIL watchdog: run did not complete (act=hung exp=done)");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model_flat();
    logic [127:0] f;
    for (int i = 0; i < 16; i++) f[i*8 +: 8] = mregs[i];
    return f;
  endfunction

  function automatic int lat();
    return (mode == 2'b10) ? 3 : 2;
  endfunction

  task automatic check_state(input string req);
    check({req, " regs"}, regs_flat, model_flat());
    check({req, " err"}, {127'd0, err_sticky}, {127'd0, m_err});
  endtask

  // one frame: strobe, control slot, data slot, idle
  task automatic frame(input bit hc, input logic [7:0] c, input bit hr, input logic [7:0] d);
    int l;
    logic [7:0] ec;
    logic [8:0] er;
    logic exp_v0, exp_v1;
    bit dual, desync, mis, ok;
    @(negedge clk) frame_strb = 1'b1;
    @(negedge clk) frame_strb = 1'b0;
    k++;
    l  = lat();
    ec = (k - l >= 1) ? ctl_hist[k-l] : 8'h00;
    er = (k - l - 1 >= 1) ? rd_hist[k-l-1] : 9'h000;
    check("R5 echo", {122'd0, tx_ctl[5:0]}, {122'd0, ec[5:0]});
    check("R3 read data", {120'd0, tx_reg}, {120'd0, (er[8] ? er[7:0] : 8'h00)});
    if (mode[1]) begin
      exp_v0 = smp_new[0] & ~cdc_pd[0];
      exp_v1 = smp_new[1] & ~cdc_pd[1];
      check("R7 validity", {126'd0, tx_ctl[7:6]}, {126'd0, exp_v0, exp_v1});
    end else begin
      check("R8 dual flags", {126'd0, tx_ctl[7:6]}, {126'd0, ~cdc_pd[0], 1'b1});
    end
    if (cdc_pd[0]) check("R6 v0 off", {127'd0, tx_ctl[7]}, 128'd0);
    check_state("R1");
    ctl_vld = hc; ctl_byte = c;
    ctl_hist[k] = hc ? c : 8'h00;
    rd_hist[k]  = 9'h000;
    if (hc) begin
      dual   = !mode[1];
      desync = dual && !c[6];
      mis    = c[5] && !desync && dual && !c[3] && (c[0] != port_idx);
      ok     = c[5] && !desync && !mis;
      if (mis) m_err = 1'b1;
      if (ok && c[4]) rd_hist[k] = {1'b1, mregs[c[3:0]]};
      m_pend  = ok && !c[4];
      m_waddr = c[3:0];
    end
    @(negedge clk) ctl_vld = 1'b0; reg_vld = hr; reg_wdata = d;
    if (hr && m_pend) begin
      mregs[m_waddr] = d;
      m_pend = 1'b0;
    end else if (hr) begin
      m_pend = 1'b0;
    end
    @(negedge clk) reg_vld = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
    for (int i = 0; i < HN; i++) begin ctl_hist[i] = 8'h00; rd_hist[i] = 9'h000; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state at the ports
    check("R10 echo", {122'd0, tx_ctl[5:0]}, 128'd0);
    check("R10 tx_reg", {120'd0, tx_reg}, 128'd0);
    check_state("R10");

    // R1 R3 R9: write then read every address from both ports in every mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int p = 0; p < 2; p++) begin
        port_idx = 1'(p);
        for (int a = 0; a < 16; a++) begin
          logic [7:0] wv;
          wv = 8'((a * 29 + m * 71 + p * 13 + 5) & 255);
          if (mode == 2'b01) begin
            frame(1, {4'b1110, 4'(a)}, 0, 8'h00);
            frame(0, 8'h00, 1, wv);
          end else begin
            frame(1, {4'b1110, 4'(a)}, 1, wv);
          end
          frame(1, {4'b0111, 4'(a)}, 0, 8'h00);
        end
        check_state("R9");
      end
      for (int f = 0; f < 4; f++) frame(0, 8'h00, 0, 8'h00);
    end

    // R2: enable low, write and read flavours, in single and dual modes
    for (int m = 1; m < 4; m += 2) begin
      mode = 2'(m); port_idx = 1'b0;
      for (int a = 0; a < 16; a += 3) begin
        frame(1, {4'b1100, 4'(a)}, 1, 8'hEE);
        check_state("R2");
        frame(1, {4'b1101, 4'(a)}, 1, 8'hDD);
      end
      for (int f = 0; f < 4; f++) frame(0, 8'h00, 0, 8'h00);
    end

    // R4: dual mode, marker low on otherwise acceptable accesses
    mode = 2'b00; port_idx = 1'b1;
    for (int a = 8; a < 16; a++) begin
      frame(1, {4'b1010, 4'(a)}, 1, 8'h5A);
      check_state("R4");
      frame(1, {4'b1011, 4'(a)}, 0, 8'h00);
    end
    for (int f = 0; f < 4; f++) frame(0, 8'h00, 0, 8'h00);

    // R6 R7 R8: validity sweep
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      for (int pd = 0; pd < 4; pd++) begin
        for (int nw = 0; nw < 4; nw++) begin
          cdc_pd = 2'(pd); smp_new = 2'(nw);
          frame(1, {4'b0100, 4'(nw * 4 + pd)}, 0, 8'h00);
        end
      end
    end
    cdc_pd = '0; smp_new = '0;
    for (int f = 0; f < 4; f++) frame(0, 8'h00, 0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule